// File: doc/BRIEF.md
# Register-Triggered 40-bit Multiply-Accumulate Unit

This block is a small arithmetic peripheral on a 32-bit register bus. It keeps one 40-bit accumulator and one 16-bit operand-0 register. Software writes operand 0 to one of two addresses, and the address it uses decides whether operand 0 counts as signed or unsigned. Software then writes operand 1 to an operation address. That single write starts a multiply, a multiply-accumulate, a 16-bit add or a 32-bit add. The operation address also decides whether operand 1 counts as signed or unsigned. Every operation finishes on the clock edge that accepts the write, so a read in the next cycle returns the new accumulator.

The accumulator is read through 16-bit windows, each one bit above the last, and a separate 8-bit view shows the top byte. This lets software take a scaled result without shifting in software. Single-bit shift commands, a clear command and three partial load addresses complete the control set. A separate leading-zero and leading-sign counter block watches the accumulator output and returns its two counts. This unit only places those counts on the bus.

Top module: `mac40_regs`

## Requirements
- R1: After reset the accumulator is zero, operand 0 is zero and operand 0 is unsigned. An unsigned 32-bit add with operand 1 of zero then leaves the accumulator at zero, and a multiply gives zero.
- R2: A write to 0x00 stores wdata[15:0] as signed operand 0, and a write to 0x04 stores it as unsigned. Operand 0 keeps its value and its signedness until the next such write, across any number of operations.
- R3: A write to 0x08 (operand 1 signed) or 0x0C (operand 1 unsigned) sets the accumulator to operand 1 times operand 0. Each operand is sign-extended or zero-extended by its own signedness, and the result is taken modulo 2^40.
- R4: A write to 0x10 (signed) or 0x14 (unsigned) adds that same product to the accumulator, wrapping modulo 2^40.
- R5: A write to 0x18 (signed) or 0x1C (unsigned) adds operand 1, extended by its signedness, to the accumulator.
- R6: A write to 0x20 (signed) or 0x24 (unsigned) adds a 32-bit value to the accumulator. Operand 1 forms the upper half of that value and the stored operand 0 forms the lower half. The value is extended to 40 bits by the signedness of the address written.
- R7: Any write to 0x34 clears all 40 accumulator bits.
- R8: A write to 0x30 shifts the accumulator by one bit, and only one of three shifts takes effect.
  - Bit 2 set: shift left, with 0 entering bit 0.
  - Bit 2 clear, bit 1 set: logical shift right, with 0 entering bit 39.
  - Only bit 0 set: arithmetic shift right, which keeps bit 39.
  - No bit set: no change.
- R9: A read of 0x38+4n, for n from 0 to 24, returns accumulator bits [n+15:n] in rdata[15:0]. A read of 0x9C returns bits [39:32] in rdata[7:0]. All other rdata bits read zero.
- R10: Writes to 0x38, 0x78 and 0x9C load accumulator bits [15:0], [31:16] and [39:32] from the low bits of wdata. All other accumulator bits keep their values.
- R11: A read of 0x28 returns the leading-zero count input in rdata[5:0], and a read of 0x2C returns the leading-sign count input. Writes to these two addresses do not change the accumulator.
- R12: Reads of operand and command addresses (0x00 to 0x24, 0x30, 0x34) return zero, as do reads of undefined or misaligned addresses. Writes to undefined addresses and to window addresses other than 0x38, 0x78 and 0x9C leave the accumulator unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 8 | Byte address of the register access |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| lz_cnt_i | input | 6 | Leading-zero count from the external counter |
| ls_cnt_i | input | 6 | Leading-sign count from the external counter |
| acc_o | output | 40 | Accumulator value, feeds the external counter |

## Verification
The arithmetic operations are swept over every pairing of six operand values: zero, one, the largest and smallest signed 16-bit values, all ones, and an ordinary pattern. Each pairing is run under all four combinations of operand signedness. All ones and 0x8000 take different results under signed and unsigned extension, so a wrong extension on either operand shows up. Repeated multiply-accumulates with large unsigned products cross the 40-bit boundary, which exposes carries that are lost or wrongly kept. A known irregular pattern is loaded in pieces and read through every window, which catches an off-by-one window offset. Shifts run on a negative value with two and three command bits set together, which separates the three shifts and checks their priority.

// File: rtl/mac40_regs.sv
module mac40_regs #(
  parameter int ACC_W = 40,
  parameter int OP_W  = 16,
  parameter int AW    = 8,
  parameter int DW    = 32,
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW-1:0]    bus_addr,
  input  logic             bus_we,
  input  logic [DW-1:0]    bus_wdata,
  output logic [DW-1:0]    bus_rdata,
  input  logic [CNT_W-1:0] lz_cnt_i,
  input  logic [CNT_W-1:0] ls_cnt_i,
  output logic [ACC_W-1:0] acc_o
);
  localparam int NWIN  = ACC_W - OP_W + 1;
  localparam int TOP_W = ACC_W - 2*OP_W;
  localparam int EXT1  = ACC_W - OP_W;
  localparam int EXT2  = ACC_W - 2*OP_W;

  localparam logic [AW-1:0] A_OP0S    = AW'('h00);
  localparam logic [AW-1:0] A_OP0U    = AW'('h04);
  localparam logic [AW-1:0] A_MULS    = AW'('h08);
  localparam logic [AW-1:0] A_MULU    = AW'('h0C);
  localparam logic [AW-1:0] A_MACS    = AW'('h10);
  localparam logic [AW-1:0] A_MACU    = AW'('h14);
  localparam logic [AW-1:0] A_ADD16S  = AW'('h18);
  localparam logic [AW-1:0] A_ADD16U  = AW'('h1C);
  localparam logic [AW-1:0] A_ADD32S  = AW'('h20);
  localparam logic [AW-1:0] A_ADD32U  = AW'('h24);
  localparam logic [AW-1:0] A_LZC     = AW'('h28);
  localparam logic [AW-1:0] A_LSC     = AW'('h2C);
  localparam logic [AW-1:0] A_SHIFT   = AW'('h30);
  localparam logic [AW-1:0] A_CLEAR   = AW'('h34);
  localparam logic [AW-1:0] A_WIN0    = AW'('h38);
  localparam logic [AW-1:0] A_WINHI   = AW'('h38 + 4*OP_W);
  localparam logic [AW-1:0] A_WINTOP  = AW'('h38 + 4*NWIN);

  logic [ACC_W-1:0] acc_q;
  logic [OP_W-1:0]  op0_q;
  logic             op0_sgn;

  logic [OP_W-1:0]  wr_op;
  logic             op1_sgn;
  logic [ACC_W-1:0] op0_x, op1_x, prod, add32_x;

  assign acc_o   = acc_q;
  assign wr_op   = bus_wdata[OP_W-1:0];
  // address bit 2 set marks the unsigned twin of each trigger
  assign op1_sgn = ~bus_addr[2];
  assign op0_x   = {{EXT1{op0_sgn & op0_q[OP_W-1]}}, op0_q};
  assign op1_x   = {{EXT1{op1_sgn & wr_op[OP_W-1]}}, wr_op};
  assign prod    = op0_x * op1_x;
  assign add32_x = {{EXT2{op1_sgn & wr_op[OP_W-1]}}, wr_op, op0_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q   <= '0;
      op0_q   <= '0;
      op0_sgn <= 1'b0;
    end else if (bus_we) begin
      case (bus_addr)
        A_OP0S, A_OP0U: begin
          op0_q   <= wr_op;
          op0_sgn <= (bus_addr == A_OP0S);
        end
        A_MULS, A_MULU:     acc_q <= prod;
        A_MACS, A_MACU:     acc_q <= acc_q + prod;
        A_ADD16S, A_ADD16U: acc_q <= acc_q + op1_x;
        A_ADD32S, A_ADD32U: acc_q <= acc_q + add32_x;
        A_SHIFT: begin
          if (bus_wdata[2])      acc_q <= {acc_q[ACC_W-2:0], 1'b0};
          else if (bus_wdata[1]) acc_q <= {1'b0, acc_q[ACC_W-1:1]};
          else if (bus_wdata[0]) acc_q <= {acc_q[ACC_W-1], acc_q[ACC_W-1:1]};
        end
        A_CLEAR:  acc_q <= '0;
        A_WIN0:   acc_q[OP_W-1:0]         <= wr_op;
        A_WINHI:  acc_q[2*OP_W-1:OP_W]    <= wr_op;
        A_WINTOP: acc_q[ACC_W-1:2*OP_W]   <= bus_wdata[TOP_W-1:0];
        default: ;
      endcase
    end
  end

  logic [AW-1:0] win_off;
  logic          win_hit;
  assign win_off = bus_addr - A_WIN0;
  assign win_hit = (bus_addr >= A_WIN0) && (bus_addr < A_WINTOP) && (win_off[1:0] == 2'b00);

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == A_LZC)         bus_rdata[CNT_W-1:0] = lz_cnt_i;
    else if (bus_addr == A_LSC)    bus_rdata[CNT_W-1:0] = ls_cnt_i;
    else if (bus_addr == A_WINTOP) bus_rdata[TOP_W-1:0] = acc_q[ACC_W-1:2*OP_W];
    else if (win_hit)              bus_rdata[OP_W-1:0]  = acc_q[win_off[AW-1:2] +: OP_W];
  end

  logic acc_touch;
  assign acc_touch = ((bus_addr >= A_MULS) && (bus_addr <= A_ADD32U) && (bus_addr[1:0] == 2'b00))
                   || bus_addr == A_SHIFT || bus_addr == A_CLEAR
                   || bus_addr == A_WIN0 || bus_addr == A_WINHI || bus_addr == A_WINTOP;

  // R7
  clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == A_CLEAR) |=> (acc_o == '0));

  // R8
  shift_left_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == A_SHIFT && bus_wdata[2]) |=> (acc_o == {$past(acc_o[ACC_W-2:0]), 1'b0}));

  // R10
  low_load_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == A_WIN0) |=> (acc_o[ACC_W-1:OP_W] == $past(acc_o[ACC_W-1:OP_W])));

  // R12
  ignored_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && !acc_touch) |=> $stable(acc_o));

  // R12
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_we |=> $stable(acc_o));
endmodule

// File: tb/tb_mac40_regs.sv
module tb_mac40_regs;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [5:0]  lz_cnt_i = '0;
  logic [5:0]  ls_cnt_i = '0;
  logic [39:0] acc_o;

  int nchk = 0;
  int nerr = 0;
  logic [39:0] m;

  always #10 clk = ~clk;

  mac40_regs dut (.clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
                  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .lz_cnt_i(lz_cnt_i),
                  .ls_cnt_i(ls_cnt_i), .acc_o(acc_o));

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0; bus_wdata = 32'hDEAD_BEEF;
  endtask

  task automatic rd(input string req, input logic [7:0] a, input logic [31:0] exp);
    bus_we = 1'b0; bus_addr = a;
    #1;
    chk(req, {32'd0, bus_rdata}, {32'd0, exp});
  endtask

  function automatic longint xv(input logic [15:0] v, input bit s);
    return s ? longint'($signed(v)) : longint'(v);
  endfunction

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  endtask

  initial begin
    #4_000_000;
    nchk++; nerr++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [15:0] vals [6];
    vals = '{16'h0000, 16'h0001, 16'h7FFF, 16'h8000, 16'hFFFF, 16'h1234};

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 acc after reset", {24'd0, acc_o}, 64'd0);
    rd("R1 window0 after reset", 8'h38, 32'd0);
    wr(8'h24, 32'h0000_0000);
    chk("R1 op0 zero via add32", {24'd0, acc_o}, 64'd0);
    wr(8'h0C, 32'h0000_FFFF);
    chk("R1 op0 zero via mul", {24'd0, acc_o}, 64'd0);

    // R2..R6 sweep over operands and signedness
    foreach (vals[i]) for (int s0 = 0; s0 < 2; s0++) begin
      wr(s0 ? 8'h00 : 8'h04, {16'hABCD, vals[i]});
      foreach (vals[j]) for (int s1 = 0; s1 < 2; s1++) begin
        longint p;
        longint a32;
        p = xv(vals[i], s0 != 0) * xv(vals[j], s1 != 0);
        m = 40'(p);
        wr(s1 ? 8'h08 : 8'h0C, {16'h5555, vals[j]});
        chk("R3 multiply", {24'd0, acc_o}, {24'd0, m});
        m = m + 40'(p);
        wr(s1 ? 8'h10 : 8'h14, {16'h0, vals[j]});
        chk("R4 multiply-accumulate", {24'd0, acc_o}, {24'd0, m});
        m = m + 40'(xv(vals[j], s1 != 0));
        wr(s1 ? 8'h18 : 8'h1C, {16'hFFFF, vals[j]});
        chk("R5 add16", {24'd0, acc_o}, {24'd0, m});
        a32 = s1 ? longint'($signed({vals[j], vals[i]})) : longint'({vals[j], vals[i]});
        m = m + 40'(a32);
        wr(s1 ? 8'h20 : 8'h24, {16'h0, vals[j]});
        chk("R6 add32 (R2 op0 retained)", {24'd0, acc_o}, {24'd0, m});
        rd("R9 low window", 8'h38, {16'd0, m[15:0]});
        rd("R9 top byte", 8'h9C, {24'd0, m[39:32]});
      end
    end

    // R4 wrap modulo 2^40
    wr(8'h04, 32'h0000_FFFF);
    wr(8'h38, 32'h0000_0000); wr(8'h78, 32'h0000_0000); wr(8'h9C, 32'h0000_00FF);
    m = 40'hFF_0000_0000;
    for (int k = 0; k < 300; k++) begin
      m = m + 40'(longint'(32'hFFFE_0001));
      wr(8'h14, 32'h0000_FFFF);
    end
    chk("R4 wrap after unsigned accumulation", {24'd0, acc_o}, {24'd0, m});

    // R10 partial loads, R9 every window
    wr(8'h34, 32'h0);
    wr(8'h9C, 32'hFFFF_FFA5);
    chk("R10 top byte load", {24'd0, acc_o}, 64'h00_A5_0000_0000);
    wr(8'h78, 32'h1111_3C96);
    wr(8'h38, 32'h2222_F00F);
    m = 40'hA5_3C96_F00F;
    chk("R10 three loads", {24'd0, acc_o}, {24'd0, m});
    for (int n = 0; n < 25; n++)
      rd($sformatf("R9 window %0d", n), 8'(8'h38 + 4*n), {16'd0, 16'(m >> n)});
    rd("R9 top byte view", 8'h9C, 32'h0000_00A5);

    // R12 writes to other windows and undefined addresses ignored
    wr(8'h3C, 32'h0000_1234); wr(8'h74, 32'h0000_1234); wr(8'hA0, 32'hFFFF_FFFF);
    wr(8'h39, 32'hFFFF_FFFF); wr(8'hFC, 32'hFFFF_FFFF);
    chk("R12 ignored writes", {24'd0, acc_o}, {24'd0, m});
    wr(8'h28, 32'hFFFF_FFFF); wr(8'h2C, 32'h0);
    chk("R11 count addresses not writable", {24'd0, acc_o}, {24'd0, m});
    wr(8'h30, 32'h0000_0000);
    chk("R8 shift with no bit set", {24'd0, acc_o}, {24'd0, m});

    // R8 shifts and priority (acc negative: bit 39 set)
    wr(8'h30, 32'h0000_0001);
    m = {m[39], m[39:1]};
    chk("R8 arithmetic right", {24'd0, acc_o}, {24'd0, m});
    wr(8'h30, 32'h0000_0003);
    m = {1'b0, m[39:1]};
    chk("R8 logical right wins over arithmetic", {24'd0, acc_o}, {24'd0, m});
    wr(8'h30, 32'h0000_0007);
    m = {m[38:0], 1'b0};
    chk("R8 left wins over both", {24'd0, acc_o}, {24'd0, m});
    wr(8'h30, 32'h0000_0004);
    m = {m[38:0], 1'b0};
    chk("R8 shift left alone", {24'd0, acc_o}, {24'd0, m});
    wr(8'h30, 32'h0000_0002);
    m = {1'b0, m[39:1]};
    chk("R8 logical right alone", {24'd0, acc_o}, {24'd0, m});

    // R11 counter inputs
    lz_cnt_i = 6'h15; ls_cnt_i = 6'h2A;
    rd("R11 leading-zero read", 8'h28, 32'h15);
    rd("R11 leading-sign read", 8'h2C, 32'h2A);

    // R12 reads of non-readable addresses
    foreach (vals[i]) ;
    for (int a = 0; a <= 8'h24; a += 4)
      rd("R12 command address reads zero", 8'(a), 32'd0);
    rd("R12 shift reads zero", 8'h30, 32'd0);
    rd("R12 clear reads zero", 8'h34, 32'd0);
    rd("R12 undefined A0", 8'hA0, 32'd0);
    rd("R12 undefined FC", 8'hFC, 32'd0);
    rd("R12 misaligned 3A", 8'h3A, 32'd0);

    // R7 clear
    wr(8'h34, 32'h0000_0000);
    chk("R7 clear", {24'd0, acc_o}, 64'd0);
    rd("R7 clear window", 8'h78, 32'd0);

    finish_run();
  end
endmodule